// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block decides when a small CPU core leaves its normal instruction flow to enter exception handling, and it runs the entry sequence itself. It handles three sources. Reset comes from release of the reset input or from a watchdog overflow pulse. Interrupts are a non-maskable request plus a vector of maskable request lines. A trap is signalled by a strobe from the executing instruction. Reset takes priority over interrupts, and interrupts take priority over the trap. Interrupts are sampled only at an instruction boundary or at the end of an entry sequence that has just finished.

For an interrupt or trap, the block captures the stack pointer, program counter and condition byte. It writes two 16-bit words below the stack pointer over a simple single-cycle memory bus. It then sets the interrupt mask bit in the condition byte, writes back the new stack pointer, reads the vector word and loads it as the new program counter. Reset entry reads the vector and jumps without touching the stack. After any reset entry, every interrupt source is held off until software writes the stack pointer. The non-maskable source is held off too.

States: `ST_RST` (reset held) goes to `ST_VEC` on the first clock after release. `ST_RUN` (normal execution) goes to `ST_SPRD` when a source is accepted. `ST_SPRD` (capture stack pointer, PC and condition byte) steps through `ST_PUSHL` (write PC low word) and `ST_PUSHH` (write condition byte with PC high bits) to `ST_MASK` (set mask bit, load new stack pointer). From there it steps through `ST_VEC` (read vector) to `ST_JUMP` (load PC). `ST_JUMP` returns to `ST_RUN`, or goes straight to `ST_SPRD` when an interrupt is pending and allowed. A watchdog pulse forces any state to `ST_VEC` with the reset vector.

Top module: `exc_entry_seq`

## Requirements
- R1: While the reset input is low, `busy` is 1 and the bus is idle. On the first cycle after release, a read at address 0x0000 is issued. The next cycle loads `pc_out` = zero-extended read word. No memory write and no `ccr_load` occur.
- R2: A one-cycle `wdt_ovf` pulse in any state produces a vector read at 0x0000 in the following cycle and a PC load in the cycle after. The sequence in progress is abandoned and no write is issued.
- R3: After reset release or a watchdog entry, neither `nmi_req` nor any `irq_req` line is accepted until a `sp_wr` pulse has been seen.
- R4: An interrupt request is accepted only in a cycle where `insn_end` is 1 in normal execution, or at the last cycle of an interrupt or trap entry sequence.
- R5: An `insn_end` with `insn_cls` = 2'b01 (control-register logic or load) does not accept a pending interrupt. The next `insn_end` of any other class does.
- R6: Maskable lines are ignored while `ccr_in` bit 7 (interrupt mask) is 1. `nmi_req` is not affected by that bit.
- R7: Among simultaneous sources, non-maskable beats maskable, and the lowest-numbered maskable line beats higher ones. An accepted interrupt beats a `trap_go` in the same cycle, and that trap strobe is dropped.
- R8: `trap_go` in normal execution is accepted regardless of the mask bit and of the post-reset lock.
- R9: Taking a source in cycle c gives two writes. In cycle c+2, `pc[15:0]` is written at SP-2. In cycle c+3, {condition byte, `pc[23:16]`} is written at SP-4. SP is the `sp_in` value one cycle after acceptance.
- R10: In cycle c+4, `ccr_load` drives the captured condition byte with bit 7 set, and `sp_load` drives SP-4. This happens before the vector read.
- R11: In cycle c+5, the vector read address is 0x001C for non-maskable, 0x0020 + 4*`trap_num` for a trap, and 0x0040 + 4*line for maskable line. In cycle c+6, `pc_out` is the read word zero-extended.
- R12: An allowed interrupt pending in the PC-load cycle of an interrupt or trap sequence starts a new sequence in the next cycle, with no `insn_end` needed. That sequence pushes the freshly loaded PC and updated condition byte.
- R13: `busy` is 0 only in normal execution. `mem_wr` and `mem_rd` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset input, active low; release starts reset entry |
| wdt_ovf | input | 1 | Watchdog overflow pulse, forces reset entry |
| nmi_req | input | 1 | Non-maskable interrupt request (level) |
| irq_req | input | NIRQ | Maskable interrupt request lines (level) |
| insn_end | input | 1 | Instruction boundary strobe |
| insn_cls | input | 2 | Class of the finishing instruction; 2'b01 blocks interrupt sampling |
| trap_go | input | 1 | Trap instruction executed strobe |
| trap_num | input | TNW | Trap number |
| sp_wr | input | 1 | Software wrote the stack pointer; unlocks interrupts |
| pc_in | input | PCW | Current program counter |
| ccr_in | input | CW | Current condition byte (bit 7 = interrupt mask) |
| sp_in | input | AW | Current stack pointer |
| mem_rdata | input | DW | Read data, valid in the cycle `mem_rd` is high |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| ccr_load | output | 1 | Load `ccr_out` into the condition byte |
| ccr_out | output | CW | New condition byte |
| sp_load | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | AW | New stack pointer |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | PCW | New program counter |
| busy | output | 1 | Entry sequence in progress or reset held |

## Verification
A wrong state or transition shows within one cycle as a bus strobe that is missing, extra or out of order. The bench compares every bus, load and strobe cycle against a queue of expected events built from the requirements. A corrupted captured stack pointer, PC or condition byte shows two to four cycles after acceptance, as a wrong write address or data or a wrong mask load. A wrong vector choice shows five cycles after acceptance as a wrong read address. A lock or sampling-window fault shows as an entry that should not happen at the next boundary, or as a missing one.

// File: rtl/exc_seq_pkg.sv
`timescale 1ns/1ps
package exc_seq_pkg;

    typedef enum logic [2:0] {
        ST_RST,
        ST_RUN,
        ST_SPRD,
        ST_PUSHL,
        ST_PUSHH,
        ST_MASK,
        ST_VEC,
        ST_JUMP
    } seq_st_t;

    typedef enum logic [1:0] {
        SRC_RST,
        SRC_NMI,
        SRC_IRQ,
        SRC_TRAP
    } src_t;

    // instruction class that closes the interrupt sampling window
    localparam logic [1:0] CLS_CCRMOD = 2'b01;

endpackage

// File: rtl/exc_irq_lock.sv
`timescale 1ns/1ps
module exc_irq_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic relock,
    input  logic unlock,
    output logic locked
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked <= 1'b1;
        end else if (relock) begin
            locked <= 1'b1;
        end else if (unlock) begin
            locked <= 1'b0;
        end
    end

endmodule

// File: rtl/exc_src_arbiter.sv
`timescale 1ns/1ps
module exc_src_arbiter
    import exc_seq_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NIRQ = 4,
    parameter int TNW  = 2,
    parameter logic [AW-1:0] NMI_VEC   = 16'h001C,
    parameter logic [AW-1:0] TRAP_BASE = 16'h0020,
    parameter logic [AW-1:0] IRQ_BASE  = 16'h0040
) (
    input  logic            window,
    input  logic            trap_en,
    input  logic            locked,
    input  logic            masked,
    input  logic            nmi_req,
    input  logic [NIRQ-1:0] irq_req,
    input  logic            trap_go,
    input  logic [TNW-1:0]  trap_num,
    output logic            take,
    output src_t            src,
    output logic [AW-1:0]   vec
);

    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic          int_open;
    logic          nmi_hit;
    logic          irq_hit;
    logic          trap_hit;
    logic [IW-1:0] irq_idx;

    always_comb begin
        irq_idx = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (irq_req[i]) begin
                irq_idx = IW'(i);
            end
        end
    end

    assign int_open = window && !locked;
    assign nmi_hit  = int_open && nmi_req;
    assign irq_hit  = int_open && !masked && (|irq_req);
    assign trap_hit = trap_en && trap_go;
    assign take     = nmi_hit || irq_hit || trap_hit;

    always_comb begin
        if (nmi_hit) begin
            src = SRC_NMI;
            vec = NMI_VEC;
        end else if (irq_hit) begin
            src = SRC_IRQ;
            vec = IRQ_BASE + (AW'(irq_idx) << 2);
        end else begin
            src = SRC_TRAP;
            vec = TRAP_BASE + (AW'(trap_num) << 2);
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int PCW   = 24,
    parameter int CW    = 8,
    parameter int NIRQ  = 4,
    parameter int TNW   = 2,
    parameter int I_BIT = 7,
    parameter logic [AW-1:0] RST_VEC   = 16'h0000,
    parameter logic [AW-1:0] NMI_VEC   = 16'h001C,
    parameter logic [AW-1:0] TRAP_BASE = 16'h0020,
    parameter logic [AW-1:0] IRQ_BASE  = 16'h0040
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wdt_ovf,
    input  logic            nmi_req,
    input  logic [NIRQ-1:0] irq_req,
    input  logic            insn_end,
    input  logic [1:0]      insn_cls,
    input  logic            trap_go,
    input  logic [TNW-1:0]  trap_num,
    input  logic            sp_wr,
    input  logic [PCW-1:0]  pc_in,
    input  logic [CW-1:0]   ccr_in,
    input  logic [AW-1:0]   sp_in,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_wr,
    output logic            mem_rd,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            ccr_load,
    output logic [CW-1:0]   ccr_out,
    output logic            sp_load,
    output logic [AW-1:0]   sp_out,
    output logic            pc_load,
    output logic [PCW-1:0]  pc_out,
    output logic            busy
);

    localparam int          WBYTES = DW / 8;
    localparam logic [AW-1:0] STEP1 = AW'(WBYTES);
    localparam logic [AW-1:0] STEP2 = AW'(2 * WBYTES);
    localparam logic [CW-1:0] IMASK = CW'(1) << I_BIT;

    seq_st_t         st_q, st_d;
    src_t            src_q;
    logic [AW-1:0]   vec_q;
    logic [PCW-1:0]  pc_q;
    logic [CW-1:0]   ccr_q;
    logic [AW-1:0]   sp_q;
    logic [DW-1:0]   rd_q;

    logic            locked;
    logic            window;
    logic            trap_en;
    logic            arb_take;
    src_t            arb_src;
    logic [AW-1:0]   arb_vec;
    logic            accept;

    // interrupt lock: armed by reset or watchdog, cleared by a stack pointer write
    exc_irq_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .relock (wdt_ovf),
        .unlock (sp_wr),
        .locked (locked)
    );

    assign window = (st_q == ST_RUN && insn_end && insn_cls != CLS_CCRMOD)
                 || (st_q == ST_JUMP && src_q != SRC_RST);
    assign trap_en = (st_q == ST_RUN);

    exc_src_arbiter #(
        .AW        (AW),
        .NIRQ      (NIRQ),
        .TNW       (TNW),
        .NMI_VEC   (NMI_VEC),
        .TRAP_BASE (TRAP_BASE),
        .IRQ_BASE  (IRQ_BASE)
    ) u_arb (
        .window   (window),
        .trap_en  (trap_en),
        .locked   (locked),
        .masked   (ccr_in[I_BIT]),
        .nmi_req  (nmi_req),
        .irq_req  (irq_req),
        .trap_go  (trap_go),
        .trap_num (trap_num),
        .take     (arb_take),
        .src      (arb_src),
        .vec      (arb_vec)
    );

    assign accept = arb_take && (st_q == ST_RUN || st_q == ST_JUMP) && !wdt_ovf;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RST:   st_d = ST_VEC;
            ST_RUN:   st_d = accept ? ST_SPRD : ST_RUN;
            ST_SPRD:  st_d = ST_PUSHL;
            ST_PUSHL: st_d = ST_PUSHH;
            ST_PUSHH: st_d = ST_MASK;
            ST_MASK:  st_d = ST_VEC;
            ST_VEC:   st_d = ST_JUMP;
            ST_JUMP:  st_d = accept ? ST_SPRD : ST_RUN;
            default:  st_d = ST_RUN;
        endcase
        if (wdt_ovf) begin
            st_d = ST_VEC;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // source, vector and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= SRC_RST;
            vec_q <= RST_VEC;
            pc_q  <= '0;
            ccr_q <= '0;
            sp_q  <= '0;
            rd_q  <= '0;
        end else begin
            if (wdt_ovf) begin
                src_q <= SRC_RST;
                vec_q <= RST_VEC;
            end else if (accept) begin
                src_q <= arb_src;
                vec_q <= arb_vec;
            end
            if (st_q == ST_SPRD) begin
                pc_q  <= pc_in;
                ccr_q <= ccr_in;
                sp_q  <= sp_in;
            end
            if (st_q == ST_VEC) begin
                rd_q <= mem_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ccr_load  = 1'b0;
        ccr_out   = '0;
        sp_load   = 1'b0;
        sp_out    = '0;
        pc_load   = 1'b0;
        pc_out    = '0;
        busy      = (st_q != ST_RUN);
        unique case (st_q)
            ST_PUSHL: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_q - STEP1;
                mem_wdata = pc_q[DW-1:0];
            end
            ST_PUSHH: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_q - STEP2;
                mem_wdata = {ccr_q, pc_q[PCW-1:DW]};
            end
            ST_MASK: begin
                ccr_load = 1'b1;
                ccr_out  = ccr_q | IMASK;
                sp_load  = 1'b1;
                sp_out   = sp_q - STEP2;
            end
            ST_VEC: begin
                mem_rd   = 1'b1;
                mem_addr = vec_q;
            end
            ST_JUMP: begin
                pc_load = 1'b1;
                pc_out  = PCW'(rd_q);
            end
            default: begin
            end
        endcase
    end

    // checks next to the logic they guard
    always_ff @(posedge clk) begin
        if (rst_n) begin
            assert_bus_excl_R13: assert (!(mem_wr && mem_rd));
        end
    end

    property p_push_descend;
        @(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - STEP1);
    endproperty
    assert_push_descend_R9: assert property (p_push_descend);

    property p_mask_after_push;
        @(posedge clk) disable iff (!rst_n)
        ccr_load |-> (ccr_out[I_BIT] && $past(mem_wr) && sp_load);
    endproperty
    assert_mask_after_push_R10: assert property (p_mask_after_push);

    property p_jump_after_read;
        @(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(mem_rd);
    endproperty
    assert_jump_after_read_R11: assert property (p_jump_after_read);

    property p_wdt_restart;
        @(posedge clk) disable iff (!rst_n)
        wdt_ovf |=> (mem_rd && !mem_wr && mem_addr == RST_VEC);
    endproperty
    assert_wdt_restart_R2: assert property (p_wdt_restart);

    property p_locked_no_int;
        @(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && locked && !trap_go) |=> (st_q != ST_SPRD);
    endproperty
    assert_locked_no_int_R3: assert property (p_locked_no_int);

    property p_blocked_window;
        @(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && insn_end && insn_cls == CLS_CCRMOD && !trap_go) |=> (st_q != ST_SPRD);
    endproperty
    assert_blocked_window_R5: assert property (p_blocked_window);

endmodule

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;

    localparam int K_WR   = 0;
    localparam int K_MASK = 1;
    localparam int K_RD   = 2;
    localparam int K_JMP  = 3;

    typedef struct {
        int          cyc;
        int          kind;
        logic [15:0] addr;
        logic [23:0] data;
        string       req;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdt_ovf = 1'b0;
    logic        nmi_req = 1'b0;
    logic [3:0]  irq_req = '0;
    logic        insn_end = 1'b0;
    logic [1:0]  insn_cls = 2'b00;
    logic        trap_go = 1'b0;
    logic [1:0]  trap_num = '0;
    logic        sp_wr = 1'b0;
    logic [23:0] pc_reg = 24'h123456;
    logic [7:0]  ccr_reg = 8'h05;
    logic [15:0] sp_reg = 16'hFF00;
    logic [15:0] mem_rdata;
    logic        mem_wr, mem_rd, ccr_load, sp_load, pc_load, busy;
    logic [15:0] mem_addr, mem_wdata, sp_out;
    logic [7:0]  ccr_out;
    logic [23:0] pc_out;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    ev_t q[$];

    always #2 clk = ~clk;

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h1357;
    endfunction

    assign mem_rdata = memf(mem_addr);

    exc_entry_seq u_exc_entry_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdt_ovf   (wdt_ovf),
        .nmi_req   (nmi_req),
        .irq_req   (irq_req),
        .insn_end  (insn_end),
        .insn_cls  (insn_cls),
        .trap_go   (trap_go),
        .trap_num  (trap_num),
        .sp_wr     (sp_wr),
        .pc_in     (pc_reg),
        .ccr_in    (ccr_reg),
        .sp_in     (sp_reg),
        .mem_rdata (mem_rdata),
        .mem_wr    (mem_wr),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ccr_load  (ccr_load),
        .ccr_out   (ccr_out),
        .sp_load   (sp_load),
        .sp_out    (sp_out),
        .pc_load   (pc_load),
        .pc_out    (pc_out),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic add(input int c, input int k, input logic [15:0] a,
                       input logic [23:0] d, input string req);
        ev_t e;
        e.cyc = c; e.kind = k; e.addr = a; e.data = d; e.req = req;
        q.push_back(e);
    endtask

    // expected events of an interrupt or trap entry accepted in cycle c
    task automatic exp_entry(input int c, input logic [15:0] vec, input logic [23:0] pc,
                             input logic [7:0] ccr, input logic [15:0] sp, input string req);
        add(c + 2, K_WR,   sp - 16'd2, {8'h00, pc[15:0]}, "R9");
        add(c + 3, K_WR,   sp - 16'd4, {8'h00, ccr, pc[23:16]}, "R9");
        add(c + 4, K_MASK, sp - 16'd4, {16'h0000, ccr | 8'h80}, "R10");
        add(c + 5, K_RD,   vec, 24'h0, req);
        add(c + 6, K_JMP,  16'h0, {8'h00, memf(vec)}, req);
    endtask

    task automatic exp_reset(input int c, input string req);
        add(c + 1, K_RD,  16'h0000, 24'h0, req);
        add(c + 2, K_JMP, 16'h0000, {8'h00, memf(16'h0000)}, req);
    endtask

    task automatic to_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic pulse_insn(input logic [1:0] cls, output int c);
        @(negedge clk);
        insn_end = 1'b1; insn_cls = cls; c = cyc;
        @(negedge clk);
        insn_end = 1'b0; insn_cls = 2'b00;
    endtask

    task automatic pulse_trap(input logic [1:0] n, output int c);
        @(negedge clk);
        trap_go = 1'b1; trap_num = n; c = cyc;
        @(negedge clk);
        trap_go = 1'b0;
    endtask

    task automatic pulse_spwr();
        @(negedge clk); sp_wr = 1'b1;
        @(negedge clk); sp_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // per-cycle comparison against the expected event queue
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            while (q.size() > 0 && q[0].cyc < cyc) begin
                chk(1'b0, q[0].req, "missed bus event kind", 32'hFFFF, q[0].kind);
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].cyc == cyc) begin
                ev_t e;
                e = q.pop_front();
                case (e.kind)
                    K_WR:   chk(mem_wr && !mem_rd && !ccr_load && !pc_load &&
                                mem_addr == e.addr && mem_wdata == e.data[15:0],
                                e.req, "push {wr,addr,data}",
                                {mem_wr, 15'h0, mem_addr} ^ {16'h0, mem_wdata},
                                {1'b1, 15'h0, e.addr} ^ {16'h0, e.data[15:0]});
                    K_MASK: chk(ccr_load && sp_load && !mem_wr && !mem_rd &&
                                ccr_out == e.data[7:0] && sp_out == e.addr,
                                e.req, "mask {ccr,sp}",
                                {ccr_load, 7'h0, ccr_out, sp_out},
                                {1'b1, 7'h0, e.data[7:0], e.addr});
                    K_RD:   chk(mem_rd && !mem_wr && mem_addr == e.addr,
                                e.req, "vector read {rd,addr}",
                                {mem_rd, 15'h0, mem_addr}, {1'b1, 15'h0, e.addr});
                    default: chk(pc_load && !mem_wr && !mem_rd && pc_out == e.data,
                                e.req, "pc load {ld,pc}",
                                {pc_load, 7'h0, pc_out}, {1'b1, 7'h0, e.data});
                endcase
            end else if (mem_wr || mem_rd || ccr_load || pc_load) begin
                chk(1'b0, "R4", "unexpected activity {wr,rd,ccr,pc}",
                    {mem_wr, mem_rd, ccr_load, pc_load}, 32'h0);
            end
            if (pc_load)  pc_reg  = pc_out;
            if (ccr_load) ccr_reg = ccr_out;
            if (sp_load)  sp_reg  = sp_out;
        end
    end

    initial begin
        while (cyc < 20000) @(negedge clk);
        chk(1'b0, "R13", "watchdog expired", cyc, 20000);
        finish_run();
    end

    initial begin
        int c;
        logic [23:0] pc2;
        logic [7:0]  ccr2;
        logic [15:0] sp2;

        // R1: reset state and reset entry
        repeat (3) @(negedge clk);
        chk(busy && !mem_wr && !mem_rd && !pc_load, "R1", "reset state {busy,wr,rd,ld}",
            {busy, mem_wr, mem_rd, pc_load}, 4'b1000);
        c = cyc; rst_n = 1'b1;
        exp_reset(c, "R1");
        to_cyc(c + 5);
        chk(!busy, "R13", "idle after reset entry busy", busy, 0);

        // R3: locked after reset, even non-maskable
        ccr_reg = 8'h00; nmi_req = 1'b1;
        pulse_insn(2'b00, c);
        to_cyc(c + 6);
        chk(!busy, "R3", "nmi while locked busy", busy, 0);
        pulse_spwr();

        // R11: non-maskable entry once unlocked
        pulse_insn(2'b00, c);
        nmi_req = 1'b0;
        exp_entry(c, 16'h001C, pc_reg, ccr_reg, sp_reg, "R11");
        to_cyc(c + 8);

        // R4: no acceptance without a boundary
        ccr_reg = 8'h00; irq_req = 4'b0100;
        repeat (5) @(negedge clk);
        chk(!busy, "R4", "irq without insn_end busy", busy, 0);
        pulse_insn(2'b10, c);
        irq_req = 4'b0000;
        exp_entry(c, 16'h0048, pc_reg, ccr_reg, sp_reg, "R11");
        to_cyc(c + 8);

        // R6: mask bit blocks maskable, not non-maskable
        ccr_reg = 8'h80; irq_req = 4'b0010;
        pulse_insn(2'b00, c);
        to_cyc(c + 5);
        chk(!busy, "R6", "masked irq busy", busy, 0);
        irq_req = 4'b0000; nmi_req = 1'b1;
        pulse_insn(2'b00, c);
        nmi_req = 1'b0;
        exp_entry(c, 16'h001C, pc_reg, ccr_reg, sp_reg, "R6");
        to_cyc(c + 8);

        // R5: control-register instruction defers by one instruction
        ccr_reg = 8'h00; irq_req = 4'b0001;
        pulse_insn(2'b01, c);
        to_cyc(c + 4);
        chk(!busy, "R5", "blocked boundary busy", busy, 0);
        pulse_insn(2'b00, c);
        irq_req = 4'b0000;
        exp_entry(c, 16'h0040, pc_reg, ccr_reg, sp_reg, "R5");
        to_cyc(c + 8);

        // R7: lowest maskable line wins
        ccr_reg = 8'h00; irq_req = 4'b1010;
        pulse_insn(2'b00, c);
        irq_req = 4'b0000;
        exp_entry(c, 16'h0044, pc_reg, ccr_reg, sp_reg, "R7");
        to_cyc(c + 8);

        // R7: non-maskable beats maskable and trap; trap dropped
        ccr_reg = 8'h00;
        @(negedge clk);
        nmi_req = 1'b1; irq_req = 4'b0001; insn_end = 1'b1; trap_go = 1'b1; trap_num = 2'd2;
        c = cyc;
        @(negedge clk);
        nmi_req = 1'b0; irq_req = 4'b0000; insn_end = 1'b0; trap_go = 1'b0;
        exp_entry(c, 16'h001C, pc_reg, ccr_reg, sp_reg, "R7");
        to_cyc(c + 9);
        chk(!busy, "R7", "dropped trap busy", busy, 0);

        // R8 under mask, then R2 watchdog mid-sequence
        ccr_reg = 8'h80;
        pulse_trap(2'd1, c);
        exp_entry(c, 16'h0024, pc_reg, ccr_reg, sp_reg, "R8");
        to_cyc(c + 3);
        wdt_ovf = 1'b1;
        q.delete();
        exp_reset(cyc, "R2");
        @(negedge clk);
        wdt_ovf = 1'b0;
        to_cyc(c + 8);

        // R3: locked again after watchdog; R8 trap still accepted
        ccr_reg = 8'h00; nmi_req = 1'b1;
        pulse_insn(2'b00, c);
        to_cyc(c + 5);
        chk(!busy, "R3", "nmi after watchdog busy", busy, 0);
        nmi_req = 1'b0;
        pulse_trap(2'd3, c);
        exp_entry(c, 16'h002C, pc_reg, ccr_reg, sp_reg, "R8");
        to_cyc(c + 8);

        // R12: chained entry at the end of a trap sequence
        pulse_spwr();
        ccr_reg = 8'h00;
        pulse_trap(2'd1, c);
        exp_entry(c, 16'h0024, pc_reg, ccr_reg, sp_reg, "R11");
        pc2  = {8'h00, memf(16'h0024)};
        ccr2 = ccr_reg | 8'h80;
        sp2  = sp_reg - 16'd4;
        exp_entry(c + 6, 16'h001C, pc2, ccr2, sp2, "R12");
        to_cyc(c + 3);
        chk(busy, "R13", "busy mid-sequence", busy, 1);
        nmi_req = 1'b1;
        to_cyc(c + 7);
        nmi_req = 1'b0;
        to_cyc(c + 15);
        chk(!busy, "R12", "idle after chain busy", busy, 0);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R9", "pending expected events", q.size(), 0);
        finish_run();
    end

endmodule